// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Register Access

This block is a watchdog timer. Software reaches it through a simple two-phase register bus with a setup phase and an access phase. The timer counts ticks from one of two sources: every cycle of the bus clock, or single-cycle pulses on an external tick input that are already in the bus clock domain. When a programmable power-of-two interval has elapsed, the timer sets a sticky expiry flag. Through that flag it can raise an interrupt. A second, shorter stage then starts counting. If software does not restart the timer before that second interval ends, the block emits a one-cycle reset pulse.

The control and restart registers are guarded by a key. A write of the unlock word to the key register admits exactly one following write to either of these two registers. A restart clears the timer only when the data carries the restart word. The interrupt interval comes from a nonuniform table of exponents. The largest selector allowed depends on the counter width chosen at build time.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the key register reads 0, `irq_o` and `wdt_rst_o` are low, and offset 0x00 returns the `ID_VALUE` parameter.
- R2: A write of 0x5AA5 (low 16 bits) to the key register at offset 0x18 sets the key register's read value to 1. A write to control (0x10) or restart (0x14) while the key reads 0 changes nothing.
- R3: The first write to control or restart after an unlock consumes the key, and the key then reads 0. A further write needs a new unlock. A write of any other value to 0x18 also clears the key.
- R4: An unlocked write to 0x14 restarts the timer only when its low 16 bits are 0xCAFE. A restart zeroes the tick count and the second-stage count and disarms the second stage. It leaves the status flag unchanged. A restart on the same cycle as a bite suppresses the pulse.
- R5: With control bits [7:4] = s, the status flag (bit 0 at 0x1C) is set on the 2^n-th tick after a restart, where n for s = 0..15 is 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31. The count then wraps. `irq_o` equals the status flag AND control bit 2.
- R6: Writing a 1 to status bit 0 clears the flag. Writing 0 leaves it set. Status writes need no unlock. An expiry on the same cycle wins over the clear.
- R7: When control bit 3 is set, an expiry arms the second stage. After 2^(7+m) further ticks, with m = control bits [10:8], `wdt_rst_o` is high for exactly one cycle and the stage disarms.
- R8: Control bit 0 enables counting. Control bit 1 = 1 counts every bus clock cycle. Bit 1 = 0 counts only cycles where `ext_tick_i` is high. With bit 0 clear, both counts hold.
- R9: The stored interrupt selector is clamped to the largest value whose exponent is below `CNT_W`: 7 for a 16-bit counter and 15 for a 32-bit counter.
- R10: Control reads back its 11 bits at positions [10:0]: run bit 0, clock select bit 1, interrupt enable bit 2, reset enable bit 3, interrupt selector [7:4], reset selector [10:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 1 | External tick, one cycle per tick, synchronous to clk_i |
| psel_i | input | 1 | Register select |
| penable_i | input | 1 | Access phase of a transfer |
| pwrite_i | input | 1 | 1 for write, 0 for read |
| paddr_i | input | ADDR_W | Byte offset of the register |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data, combinational from paddr_i |
| irq_o | output | 1 | Expiry interrupt |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that a transfer holds `penable_i` for a single cycle per access, and that `ext_tick_i` is already synchronous to the bus clock. They also assume that only the low 16 bits of a key or restart write carry meaning. The stimulus drives every input on the falling edge and always issues a setup cycle before one access cycle. It generates the external tick as a synchronous pulse every third cycle. The long selectors appear only while counting is stopped, so every awaited interval fits in a few hundred cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] OFF_ID   = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_KICK = 8'h14;
  localparam logic [7:0] OFF_KEY  = 8'h18;
  localparam logic [7:0] OFF_STAT = 8'h1C;

  localparam logic [15:0] UNLOCK_WORD = 16'h5AA5;
  localparam logic [15:0] KICK_WORD   = 16'hCAFE;

  localparam int unsigned BARK_SEL_W = 4;
  localparam int unsigned BITE_SEL_W = 3;
  localparam int unsigned BITE_BASE  = 7;

  // field positions are software visible
  typedef struct packed {
    logic [BITE_SEL_W-1:0] bite_sel;  // [10:8]
    logic [BARK_SEL_W-1:0] bark_sel;  // [7:4]
    logic                  bite_en;   // [3]
    logic                  irq_en;    // [2]
    logic                  bus_clk;   // [1]
    logic                  run;       // [0]
  } wdog_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wdog_ctrl_t);

  // exponent of the first-stage interval for a selector
  function automatic int unsigned bark_exp(input int unsigned sel);
    if (sel == 0)      return 6;
    else if (sel == 1) return 8;
    else if (sel < 8)  return sel + 8;
    else               return 2 * sel + 1;
  endfunction

  function automatic int unsigned bite_exp(input int unsigned sel);
    return BITE_BASE + sel;
  endfunction

  // largest selector whose interval still fits a counter of cnt_w bits
  function automatic int unsigned bark_sel_max(input int unsigned cnt_w);
    int unsigned best;
    best = 0;
    for (int unsigned s = 0; s < (1 << BARK_SEL_W); s++) begin
      if (bark_exp(s) < cnt_w) best = s;
    end
    return best;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h5744_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] prdata_o,
  output wdog_ctrl_t        ctrl_o,
  output logic              kick_o,
  output logic              sts_o
);

  localparam int unsigned MAX_SEL = bark_sel_max(CNT_W);

  wdog_ctrl_t ctrl_q, ctrl_new;
  logic       key_q;
  logic       sts_q;
  logic       acc;
  logic       hit_ctrl, hit_kick, hit_key, hit_stat;
  logic       key_word_ok, kick_word_ok;

  assign acc      = psel_i && penable_i && pwrite_i;
  assign hit_ctrl = (paddr_i == ADDR_W'(OFF_CTRL));
  assign hit_kick = (paddr_i == ADDR_W'(OFF_KICK));
  assign hit_key  = (paddr_i == ADDR_W'(OFF_KEY));
  assign hit_stat = (paddr_i == ADDR_W'(OFF_STAT));

  assign key_word_ok  = (pwdata_i[15:0] == UNLOCK_WORD);
  assign kick_word_ok = (pwdata_i[15:0] == KICK_WORD);

  always_comb begin
    ctrl_new = wdog_ctrl_t'(pwdata_i[CTRL_W-1:0]);
    if (32'(ctrl_new.bark_sel) > MAX_SEL) ctrl_new.bark_sel = BARK_SEL_W'(MAX_SEL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      key_q  <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (acc && hit_ctrl && key_q) ctrl_q <= ctrl_new;

      if (acc && hit_key)                    key_q <= key_word_ok;
      else if (acc && (hit_ctrl || hit_kick)) key_q <= 1'b0;

      if (expire_i)                          sts_q <= 1'b1;
      else if (acc && hit_stat && pwdata_i[0]) sts_q <= 1'b0;
    end
  end

  assign kick_o = acc && hit_kick && key_q && kick_word_ok;
  assign ctrl_o = ctrl_q;
  assign sts_o  = sts_q;

  always_comb begin
    prdata_o = '0;
    if (paddr_i == ADDR_W'(OFF_ID))        prdata_o = DATA_W'(ID_VALUE);
    else if (hit_ctrl)                     prdata_o = DATA_W'(ctrl_q);
    else if (hit_key)                      prdata_o = DATA_W'(key_q);
    else if (hit_stat)                     prdata_o = DATA_W'(sts_q);
  end

  p_locked_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && hit_ctrl && !key_q) |=> $stable(ctrl_q));

  p_key_spent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (hit_ctrl || hit_kick)) |=> !key_q);

  p_sts_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !(acc && hit_stat && pwdata_i[0])) |=> sts_q);

  p_sel_clamp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ctrl_q.bark_sel) <= MAX_SEL);

endmodule

// File: rtl/wdog_bark.sv
module wdog_bark
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  kick_i,
  input  logic [BARK_SEL_W-1:0] bark_sel_i,
  output logic                  expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb last = CNT_W'((64'd1 << bark_exp(32'(bark_sel_i))) - 64'd1);

  assign expire_o = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (kick_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= expire_o ? '0 : cnt_q + CNT_W'(1);
  end

  p_kick_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kick_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_bite.sv
module wdog_bite
  import wdog_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  kick_i,
  input  logic                  expire_i,
  input  logic                  bite_en_i,
  input  logic [BITE_SEL_W-1:0] bite_sel_i,
  output logic                  bite_o
);

  localparam int unsigned RCNT_W = BITE_BASE + (1 << BITE_SEL_W) - 1;

  logic              armed_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic [RCNT_W-1:0] last;
  logic              step, fire;
  logic              bite_q;

  always_comb last = RCNT_W'((32'd1 << bite_exp(32'(bite_sel_i))) - 32'd1);

  assign step = armed_q && bite_en_i && tick_i;
  assign fire = step && (rcnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      rcnt_q  <= '0;
      bite_q  <= 1'b0;
    end else begin
      bite_q <= fire && !kick_i;
      if (kick_i) begin
        armed_q <= 1'b0;
        rcnt_q  <= '0;
      end else begin
        if (fire)                       armed_q <= 1'b0;
        else if (expire_i && bite_en_i) armed_q <= 1'b1;

        if (!armed_q || fire) rcnt_q <= '0;
        else if (step)        rcnt_q <= rcnt_q + RCNT_W'(1);
      end
    end
  end

  assign bite_o = bite_q;

  p_bite_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_q |=> !bite_q);

  p_kick_disarm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (!armed_q && !bite_q && rcnt_q == '0));

  p_bite_needs_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q) |=> !bite_q);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h5744_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_tick_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  wdog_ctrl_t ctrl;
  logic       kick, sts, expire, tick;

  wdog_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .ID_VALUE (ID_VALUE)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .expire_i  (expire),
    .prdata_o  (prdata_o),
    .ctrl_o    (ctrl),
    .kick_o    (kick),
    .sts_o     (sts)
  );

  assign tick = ctrl.run && (ctrl.bus_clk || ext_tick_i);

  wdog_bark #(.CNT_W(CNT_W)) u_bark (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .kick_i     (kick),
    .bark_sel_i (ctrl.bark_sel),
    .expire_o   (expire)
  );

  wdog_bite u_bite (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .kick_i     (kick),
    .expire_i   (expire),
    .bite_en_i  (ctrl.bite_en),
    .bite_sel_i (ctrl.bite_sel),
    .bite_o     (wdt_rst_o)
  );

  assign irq_o = sts && ctrl.irq_en;

  p_expire_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> sts);

  p_stopped_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |-> !expire);

endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;

  localparam logic [31:0] ID = 32'h5744_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = 8'h00;
  logic [31:0] pwdata = 32'h0;
  logic [31:0] prdata;
  logic        irq, wdt_rst;

  always #10 clk = ~clk;  // 50 MHz

  wdog_two_stage #(.CNT_W(16), .ID_VALUE(ID)) u_wdog_two_stage (
    .clk_i(clk), .rst_ni(rst_n), .ext_tick_i(ext_tick),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .irq_o(irq), .wdt_rst_o(wdt_rst)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    ext_mode = 1'b0;
  int    ph = 0;

  int bark_tab[16] = '{6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31};

  // reference model state
  int m_ctrl = 0, m_cnt = 0, m_rcnt = 0;
  bit m_key = 0, m_sts = 0, m_armed = 0, m_rst = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return ID;
      8'h10:   return 32'(m_ctrl);
      8'h18:   return 32'(m_key);
      8'h1C:   return 32'(m_sts);
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    ph = (ph + 1) % 3;
    ext_tick = ext_mode && (ph == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_rcnt = 0;
      m_key = 0; m_sts = 0; m_armed = 0; m_rst = 0;
    end else begin
      bit acc, tick, ex, kick, step, fire, n_key, n_sts, n_armed;
      int n_ctrl, n_cnt, n_rcnt, sel;
      acc  = psel && penable && pwrite;
      tick = m_ctrl[0] && (m_ctrl[1] || ext_tick);
      ex   = tick && (m_cnt == (1 << bark_tab[(m_ctrl >> 4) & 15]) - 1);
      kick = acc && paddr == 8'h14 && m_key && pwdata[15:0] == 16'hCAFE;
      step = m_armed && m_ctrl[3] && tick;
      fire = step && (m_rcnt == (1 << (7 + ((m_ctrl >> 8) & 7))) - 1);
      n_ctrl = m_ctrl;
      if (acc && paddr == 8'h10 && m_key) begin
        sel = int'(pwdata[7:4]);
        if (sel > 7) sel = 7;
        n_ctrl = (int'(pwdata[10:0]) & 32'h70F) | (sel << 4);
      end
      n_key = m_key;
      if (acc && paddr == 8'h18) n_key = (pwdata[15:0] == 16'h5AA5);
      else if (acc && (paddr == 8'h10 || paddr == 8'h14)) n_key = 0;
      n_sts = m_sts;
      if (ex) n_sts = 1;
      else if (acc && paddr == 8'h1C && pwdata[0]) n_sts = 0;
      n_cnt = m_cnt;
      if (kick) n_cnt = 0;
      else if (tick) n_cnt = ex ? 0 : (m_cnt + 1) & 16'hFFFF;
      n_armed = m_armed; n_rcnt = m_rcnt;
      if (kick) begin n_armed = 0; n_rcnt = 0; end
      else begin
        if (fire) n_armed = 0;
        else if (ex && m_ctrl[3]) n_armed = 1;
        if (!m_armed || fire) n_rcnt = 0;
        else if (step) n_rcnt = m_rcnt + 1;
      end
      m_rst = fire && !kick;
      m_ctrl = n_ctrl; m_key = n_key; m_sts = n_sts; m_cnt = n_cnt;
      m_armed = n_armed; m_rcnt = n_rcnt;
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #5;
    chk({cur_req, " irq"}, 32'(irq), 32'(m_sts && m_ctrl[2]));
    chk({cur_req, " rst"}, 32'(wdt_rst), 32'(m_rst));
    chk({cur_req, " rdata"}, prdata, m_read(paddr));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    #5 d = prdata;
    @(negedge clk); psel = 0;
  endtask

  task automatic unlocked_wr(input logic [7:0] a, input logic [31:0] d);
    wr(8'h18, 32'h5AA5);
    wr(a, d);
  endtask

  task automatic count_bites(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #5;
      if (wdt_rst) n++;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
  end

  initial begin
    logic [31:0] d;
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    rd(8'h00, d); chk("R1 id", d, ID);
    rd(8'h10, d); chk("R1 ctrl", d, 0);
    rd(8'h1C, d); chk("R1 status", d, 0);
    rd(8'h18, d); chk("R1 key", d, 0);
    chk("R1 irq", 32'(irq), 0);

    cur_req = "R2";
    wr(8'h10, 32'h0000_000F);
    rd(8'h10, d); chk("R2 locked ctrl", d, 0);
    wr(8'h18, 32'h5AA5);
    rd(8'h18, d); chk("R2 key set", d, 1);

    cur_req = "R10";
    wr(8'h10, 32'h0000_0007);
    rd(8'h10, d); chk("R10 readback", d, 32'h7);

    cur_req = "R3";
    rd(8'h18, d); chk("R3 key spent", d, 0);
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, d); chk("R3 second write ignored", d, 32'h7);
    wr(8'h18, 32'h5AA5); wr(8'h18, 32'h1111);
    rd(8'h18, d); chk("R3 wrong key clears", d, 0);

    cur_req = "R5";
    repeat (80) @(negedge clk);
    chk("R5 irq after interval", 32'(irq), 1);
    unlocked_wr(8'h10, 32'h0000_0003);
    chk("R5 irq gated", 32'(irq), 0);
    rd(8'h1C, d); chk("R5 status kept", d, 1);
    unlocked_wr(8'h10, 32'h0000_0000);

    cur_req = "R6";
    wr(8'h1C, 32'h0);
    rd(8'h1C, d); chk("R6 zero keeps", d, 1);
    wr(8'h1C, 32'h1);
    rd(8'h1C, d); chk("R6 one clears", d, 0);

    cur_req = "R7";
    unlocked_wr(8'h10, 32'h0000_000F);
    unlocked_wr(8'h14, 32'hCAFE);
    count_bites(250, nb); chk("R7 one bite", 32'(nb), 1);

    cur_req = "R4";
    unlocked_wr(8'h14, 32'hCAFE);
    repeat (100) @(negedge clk);
    unlocked_wr(8'h14, 32'h1234);
    count_bites(150, nb); chk("R4 wrong word no restart", 32'(nb), 1);
    unlocked_wr(8'h14, 32'hCAFE);
    repeat (100) @(negedge clk);
    unlocked_wr(8'h14, 32'hCAFE);
    count_bites(150, nb); chk("R4 restart prevents bite", 32'(nb), 0);
    rd(8'h1C, d); chk("R4 status not cleared", d, 1);

    cur_req = "R8";
    ext_mode = 1;
    unlocked_wr(8'h10, 32'h0000_0005);
    wr(8'h1C, 32'h1);
    unlocked_wr(8'h14, 32'hCAFE);
    repeat (150) @(negedge clk);
    chk("R8 ext slower", 32'(irq), 0);
    repeat (100) @(negedge clk);
    chk("R8 ext expiry", 32'(irq), 1);
    unlocked_wr(8'h10, 32'h0000_0006);
    wr(8'h1C, 32'h1);
    repeat (300) @(negedge clk);
    rd(8'h1C, d); chk("R8 stopped holds", d, 0);
    ext_mode = 0;

    cur_req = "R9";
    unlocked_wr(8'h10, 32'h0000_07F0);
    rd(8'h10, d); chk("R9 selector clamp", d, 32'h770);
    unlocked_wr(8'h10, 32'h0000_0117);
    unlocked_wr(8'h14, 32'hCAFE);
    repeat (300) @(negedge clk);
    chk("R5 sel1 expiry", 32'(irq), 1);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule